// File: doc/BRIEF.md
# Packet Bus Receive Monitor

This block watches the receive side of a wide packet bus that moves one word of 64 bytes per enabled cycle. Each word comes with sideband fields: a qualifying enable, start and end markers, an error flag, a 6-bit count of unused bytes in the final word, and a channel number. The monitor does not need the payload itself. It works only on the sideband fields. It follows the framing of each packet and reports each completed packet once, with its channel, its byte length and its error status.

The monitor also keeps three sticky violation flags. The first flags framing faults: a start marker inside an open packet, or a word that arrives with no packet open. The second flags a channel number that changes inside a packet. The third flags an errored end word whose empty count breaks the required encoding. Only a synchronous reset clears the flags. The monitor is placed passively beside the receive datapath and gives it no back-pressure.

Top module: `pkt_rx_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, `rpt_valid` and all three flags are 0 after that edge.
- R2: A cycle with `in_valid` low changes no packet state, produces no report and sets no flag, whatever the other inputs hold.
- R3: When an enabled word with `in_end` high belongs to an open packet, or starts one, `rpt_valid` is high for exactly the cycle after that edge. In that cycle `rpt_chan` carries the channel sampled on the packet's start word and `rpt_err` carries `in_err` from the end word.
- R4: `rpt_len` equals 64 times the number of enabled words in the packet, end word included, minus `in_empty` sampled on the end word.
- R5: A word with both `in_start` and `in_end` high is a legal one-word packet of length 64 minus `in_empty`, and it sets no flag.
- R6: A start marker while a packet is open sets `flag_framing`. The open packet is dropped without a report, and counting starts again from the new start word.
- R7: An enabled word with no packet open and `in_start` low sets `flag_framing` and is discarded. If it carries an end marker, no report follows.
- R8: An enabled, non-start word of an open packet whose `in_chan` differs from the start word's channel sets `flag_chan`. The report still carries the start word's channel.
- R9: An enabled end word with `in_err` high and `in_empty[2:0]` not equal to 000 sets `flag_encoding`. An errored end word with `in_empty[2:0]` = 000 does not set it, and neither does a non-errored end word.
- R10: `in_err` and `in_empty` on enabled words that are not end words have no effect on the reports or on `flag_encoding`.
- R11: Once set, each flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies all other inputs |
| in_start | input | 1 | Start-of-packet marker |
| in_end | input | 1 | End-of-packet marker |
| in_err | input | 1 | Packet error flag, meaningful on end words |
| in_empty | input | 6 | Unused bytes in the end word |
| in_chan | input | 8 | Channel of the packet in flight |
| rpt_valid | output | 1 | One-cycle completed-packet pulse |
| rpt_chan | output | 8 | Channel of the reported packet |
| rpt_len | output | 16 | Byte length of the reported packet |
| rpt_err | output | 1 | Error status of the reported packet |
| flag_framing | output | 1 | Sticky framing violation |
| flag_chan | output | 1 | Sticky channel-change violation |
| flag_encoding | output | 1 | Sticky errored-empty encoding violation |

## Verification
A wrong open/idle state shows up at the ports on the next enabled word. A stale open state raises `flag_framing` on a legal start, and a stale idle state drops a report. A faulty word counter gives an `rpt_len` off by a multiple of 64 one cycle after the end word. A wrong latched channel appears in `rpt_chan`, or raises `flag_chan` during the packet. The bench drives gaps with junk sideband, one-word packets, restarts, headless words and errored ends with each class of empty value, and compares every output against a behavioural model after each edge.

// File: rtl/prm_pkg.sv
package prm_pkg;
   typedef enum logic {FRM_IDLE = 1'b0, FRM_OPEN = 1'b1} frm_state_e;
   localparam int FLAG_FRAMING  = 0;
   localparam int FLAG_CHAN     = 1;
   localparam int FLAG_ENCODING = 2;
   localparam int NUM_FLAGS     = 3;
endpackage

// File: rtl/prm_frame_tracker.sv
module prm_frame_tracker
   import prm_pkg::*;
#(
   parameter int CHAN_W     = 8,
   parameter bit CHAN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic              sop,
   input  logic              eop,
   input  logic [CHAN_W-1:0] chan,
   output logic              word_acc,
   output logic              first_word,
   output logic              end_acc,
   output logic              frame_viol,
   output logic              chan_viol,
   output logic [CHAN_W-1:0] pkt_chan
);
   frm_state_e        state_q;
   logic [CHAN_W-1:0] chan_q;
   logic              is_open;

   always_comb begin
      is_open    = (state_q == FRM_OPEN);
      first_word = valid & sop;
      word_acc   = valid & (sop | is_open);
      end_acc    = word_acc & eop;
      frame_viol = valid & (sop ? is_open : ~is_open);
      pkt_chan   = sop ? chan : chan_q;
   end

   generate
      if (CHAN_CHECK) begin : g_chan_chk
         assign chan_viol = valid & ~sop & is_open & (chan != chan_q);
      end else begin : g_chan_off
         assign chan_viol = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FRM_IDLE;
         chan_q  <= '0;
      end else if (word_acc) begin
         state_q <= eop ? FRM_IDLE : FRM_OPEN;
         if (first_word) chan_q <= chan;
      end
   end

   // R2: an idle bus cycle leaves the framing state alone
   p_hold_idle_r2 : assert property (@(posedge clk) disable iff (rst)
      !valid |=> $stable(state_q));
   // R5: a start-and-end word leaves no packet open
   p_single_word_r5 : assert property (@(posedge clk) disable iff (rst)
      (valid && sop && eop) |=> state_q == FRM_IDLE);
   // R6: a restart keeps the packet open
   p_restart_open_r6 : assert property (@(posedge clk) disable iff (rst)
      (valid && sop && !eop) |=> state_q == FRM_OPEN);
endmodule

// File: rtl/prm_len_acc.sv
module prm_len_acc #(
   parameter int BYTES = 64,
   parameter int MTY_W = 6,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             word_acc,
   input  logic             first_word,
   input  logic             eop,
   input  logic [MTY_W-1:0] empty,
   output logic [LEN_W-1:0] len
);
   localparam int SHIFT = $clog2(BYTES);

   logic [LEN_W-1:0] cnt_q, cnt_n;

   always_comb begin
      cnt_n = first_word ? LEN_W'(1) : cnt_q + LEN_W'(1);
      len   = (cnt_n << SHIFT) - LEN_W'(empty);
   end

   always_ff @(posedge clk) begin
      if (rst)           cnt_q <= '0;
      else if (word_acc) cnt_q <= eop ? '0 : cnt_n;
   end

   // R4: the word count only moves on accepted words
   p_cnt_hold_r4 : assert property (@(posedge clk) disable iff (rst)
      !word_acc |=> $stable(cnt_q));
endmodule

// File: rtl/prm_enc_check.sv
module prm_enc_check #(
   parameter int MTY_W     = 6,
   parameter int ZERO_BITS = 3
) (
   input  logic             valid,
   input  logic             eop,
   input  logic             err,
   input  logic [MTY_W-1:0] empty,
   output logic             viol
);
   generate
      if (ZERO_BITS == 0) begin : g_no_rule
         assign viol = 1'b0;
      end else begin : g_rule
         assign viol = valid & eop & err & (|empty[ZERO_BITS-1:0]);
      end
   endgenerate
endmodule

// File: rtl/prm_flag_bank.sv
module prm_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
         end
         // R11: a raised flag never drops before reset
         p_sticky_r11 : assert property (@(posedge clk) disable iff (rst)
            flags[i] |=> flags[i]);
      end
   endgenerate
endmodule

// File: rtl/pkt_rx_monitor.sv
module pkt_rx_monitor
   import prm_pkg::*;
#(
   parameter int BYTES        = 64,
   parameter int MTY_W        = 6,
   parameter int CHAN_W       = 8,
   parameter int LEN_W        = 16,
   parameter int ERR_ZERO_LSB = 3,
   parameter bit CHAN_CHECK   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic              in_end,
   input  logic              in_err,
   input  logic [MTY_W-1:0]  in_empty,
   input  logic [CHAN_W-1:0] in_chan,
   output logic              rpt_valid,
   output logic [CHAN_W-1:0] rpt_chan,
   output logic [LEN_W-1:0]  rpt_len,
   output logic              rpt_err,
   output logic              flag_framing,
   output logic              flag_chan,
   output logic              flag_encoding
);
   generate
      if ((BYTES & (BYTES - 1)) != 0 || BYTES < 2) begin : g_bad_bytes
         $error("BYTES must be a power of two");
      end
      if ((1 << MTY_W) < BYTES) begin : g_bad_mty
         $error("MTY_W too narrow for BYTES");
      end
      if (ERR_ZERO_LSB < 0 || ERR_ZERO_LSB > MTY_W) begin : g_bad_zero
         $error("ERR_ZERO_LSB out of range");
      end
      if (LEN_W <= $clog2(BYTES)) begin : g_bad_len
         $error("LEN_W too narrow");
      end
   endgenerate

   logic              word_acc, first_word, end_acc;
   logic              frame_viol, chan_viol, enc_viol;
   logic [CHAN_W-1:0] pkt_chan;
   logic [LEN_W-1:0]  len;
   logic [NUM_FLAGS-1:0] flag_set, flags;

   prm_frame_tracker #(.CHAN_W(CHAN_W), .CHAN_CHECK(CHAN_CHECK)) u_track (
      .clk(clk), .rst(rst), .valid(in_valid), .sop(in_start), .eop(in_end),
      .chan(in_chan), .word_acc(word_acc), .first_word(first_word),
      .end_acc(end_acc), .frame_viol(frame_viol), .chan_viol(chan_viol),
      .pkt_chan(pkt_chan));

   prm_len_acc #(.BYTES(BYTES), .MTY_W(MTY_W), .LEN_W(LEN_W)) u_len (
      .clk(clk), .rst(rst), .word_acc(word_acc), .first_word(first_word),
      .eop(in_end), .empty(in_empty), .len(len));

   prm_enc_check #(.MTY_W(MTY_W), .ZERO_BITS(ERR_ZERO_LSB)) u_enc (
      .valid(in_valid), .eop(in_end), .err(in_err), .empty(in_empty),
      .viol(enc_viol));

   always_comb begin
      flag_set                = '0;
      flag_set[FLAG_FRAMING]  = frame_viol;
      flag_set[FLAG_CHAN]     = chan_viol;
      flag_set[FLAG_ENCODING] = enc_viol;
   end

   prm_flag_bank #(.N(NUM_FLAGS)) u_flags (
      .clk(clk), .rst(rst), .set(flag_set), .flags(flags));

   assign flag_framing  = flags[FLAG_FRAMING];
   assign flag_chan     = flags[FLAG_CHAN];
   assign flag_encoding = flags[FLAG_ENCODING];

   always_ff @(posedge clk) begin
      if (rst) begin
         rpt_valid <= 1'b0;
         rpt_chan  <= '0;
         rpt_len   <= '0;
         rpt_err   <= 1'b0;
      end else begin
         rpt_valid <= end_acc;
         if (end_acc) begin
            rpt_chan <= pkt_chan;
            rpt_len  <= len;
            rpt_err  <= in_err;
         end
      end
   end

   // R3: a report only follows an enabled end word
   p_rpt_after_end_r3 : assert property (@(posedge clk) disable iff (rst)
      rpt_valid |-> $past(in_valid && in_end));
   // R2: an idle cycle never yields a report
   p_idle_no_rpt_r2 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !rpt_valid);
   // R9: the encoding flag rises only after an errored end word
   p_enc_cause_r9 : assert property (@(posedge clk) disable iff (rst)
      $rose(flag_encoding) |-> $past(in_valid && in_end && in_err));
   // R8: the channel flag rises only after an enabled non-start word
   p_chan_cause_r8 : assert property (@(posedge clk) disable iff (rst)
      $rose(flag_chan) |-> $past(in_valid && !in_start));
   // R7: the framing flag rises only after an enabled word
   p_frame_cause_r7 : assert property (@(posedge clk) disable iff (rst)
      $rose(flag_framing) |-> $past(in_valid));
endmodule

// File: tb/pkt_rx_monitor_tb.sv
module pkt_rx_monitor_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       in_valid, in_start, in_end, in_err;
   logic [5:0] in_empty;
   logic [7:0] in_chan;
   logic       rpt_valid, rpt_err, flag_framing, flag_chan, flag_encoding;
   logic [7:0] rpt_chan;
   logic [15:0] rpt_len;

   always #4 clk = ~clk;

   pkt_rx_monitor u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
      .in_end(in_end), .in_err(in_err), .in_empty(in_empty), .in_chan(in_chan),
      .rpt_valid(rpt_valid), .rpt_chan(rpt_chan), .rpt_len(rpt_len),
      .rpt_err(rpt_err), .flag_framing(flag_framing), .flag_chan(flag_chan),
      .flag_encoding(flag_encoding));

   int n_chk = 0, n_fail = 0;
   int m_open, m_words, m_chan;
   int e_rv, e_len, e_chan, e_err, e_fr, e_ch, e_enc;
   bit finished = 1'b0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model(input bit r, input bit v, input bit s, input bit e,
                        input bit er, input int mty, input int ch);
      e_rv = 0;
      if (r) begin
         m_open = 0; m_words = 0; m_chan = 0;
         e_fr = 0; e_ch = 0; e_enc = 0;
      end else if (v) begin
         if (e && er && (mty % 8) != 0) e_enc = 1;
         if (s) begin
            if (m_open != 0) e_fr = 1;
            m_open = 1; m_words = 0; m_chan = ch;
         end else if (m_open == 0) begin
            e_fr = 1;
         end else if (ch != m_chan) begin
            e_ch = 1;
         end
         if (m_open != 0) begin
            m_words++;
            if (e) begin
               e_rv = 1; e_len = m_words * 64 - mty;
               e_chan = m_chan; e_err = er; m_open = 0;
            end
         end
      end
   endtask

   task automatic cyc(input bit r, input bit v, input bit s, input bit e,
                      input bit er, input int mty, input int ch, input string tag);
      rst = r; in_valid = v; in_start = s; in_end = e; in_err = er;
      in_empty = 6'(mty); in_chan = 8'(ch);
      @(posedge clk);
      model(r, v, s, e, er, mty, ch);
      @(negedge clk);
      chk(tag, "rpt_valid", int'(rpt_valid), e_rv);
      chk(tag, "flag_framing", int'(flag_framing), e_fr);
      chk(tag, "flag_chan", int'(flag_chan), e_ch);
      chk(tag, "flag_encoding", int'(flag_encoding), e_enc);
      if (e_rv != 0) begin
         chk(tag, "rpt_len", int'(rpt_len), e_len);
         chk(tag, "rpt_chan", int'(rpt_chan), e_chan);
         chk(tag, "rpt_err", int'(rpt_err), e_err);
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 0, i % 2, 1, 1, 7 - (i % 7), 99 + i, tag);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 0; in_start = 0; in_end = 0; in_err = 0;
      in_empty = 0; in_chan = 0;
      @(negedge clk);
      // R1: reset state
      cyc(1, 1, 1, 1, 1, 5, 3, "R1");
      cyc(1, 0, 0, 0, 0, 0, 0, "R1");
      // R3 R4 R2: three words with junk idle gaps, empty 10 -> 182
      cyc(0, 1, 1, 0, 1, 17, 5, "R3");
      idle(3, "R2");
      cyc(0, 1, 0, 0, 0, 0, 5, "R4");
      idle(2, "R2");
      cyc(0, 1, 0, 1, 0, 10, 5, "R4");
      // R5: one-word packets, lengths 64 and 1
      cyc(0, 1, 1, 1, 0, 0, 7, "R5");
      cyc(0, 1, 1, 1, 0, 63, 8, "R5");
      idle(1, "R2");
      // R10 R9: err and junk empty on middle word, errored end with low bits 000
      cyc(0, 1, 1, 0, 1, 5, 2, "R10");
      cyc(0, 1, 0, 0, 1, 3, 2, "R10");
      cyc(0, 1, 0, 1, 1, 8, 2, "R9");
      // R9: good end with nonzero low bits does not set the flag
      cyc(0, 1, 1, 1, 0, 5, 4, "R9");
      // R8: channel change mid packet
      cyc(0, 1, 1, 0, 0, 0, 11, "R8");
      cyc(0, 1, 0, 0, 0, 0, 12, "R8");
      cyc(0, 1, 0, 1, 0, 4, 11, "R8");
      // R9: errored end with empty 5 sets the flag
      cyc(0, 1, 1, 1, 1, 5, 6, "R9");
      // R7: headless word with end, no report
      cyc(0, 1, 0, 1, 0, 2, 6, "R7");
      // R11: flags persist
      idle(6, "R11");
      cyc(1, 0, 0, 0, 0, 0, 0, "R11");
      // R6: restart abandons first packet
      cyc(0, 1, 1, 0, 0, 0, 1, "R6");
      cyc(0, 1, 0, 0, 0, 0, 1, "R6");
      cyc(0, 1, 1, 0, 0, 0, 9, "R6");
      cyc(0, 1, 0, 1, 1, 16, 9, "R6");
      idle(2, "R11");
      // R7: headless word without end after reset
      cyc(1, 0, 0, 0, 0, 0, 0, "R1");
      cyc(0, 1, 0, 0, 0, 0, 3, "R7");
      cyc(0, 1, 1, 1, 0, 1, 3, "R5");
      idle(2, "R11");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule